// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects up to sixteen interrupt sources and presents them to a processor as a single request line with an 8-bit vector. Four sources are single-cycle strobes from timers elsewhere on the chip. Two sources come from a general-purpose input port, where each pin has a programmable edge polarity. Software configures and inspects the block through a byte-wide register port. Each 16-bit per-channel register (enable, pending, in-service, mask) is split into a high byte for channels 15..8 and a low byte for channels 7..0.

A higher channel number means higher priority. While a channel is in service, every lower channel is held off. When the processor acknowledges with a one-cycle strobe, the block supplies a vector built from a programmable upper nibble and the winning channel number. It clears that channel's pending bit. In the in-service mode it also marks the channel as in service, and software ends the service by clearing the bit with an AND-mask write. In the automatic mode no in-service bit is kept.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0x00 and `irq_o` is low.
- R2: A request on a channel whose enable bit is 0 does not set its pending bit. A pending bit whose enable bit is 0 is cleared on the next clock edge.
- R3: `irq_o` and `vec_o` select the highest-numbered channel that is pending and unmasked. A channel is held off while any strictly higher channel has its in-service bit set.
- R4: A pending channel whose mask bit is 0 stays pending but does not drive `irq_o`.
- R5: `vec_o` equals the vector register bits 7:4 followed by the 4-bit number of the selected channel.
- R6: An `iack` strobe while `irq_o` is high clears the selected channel's pending bit. If vector register bit 3 is 1, it also sets that channel's in-service bit. If bit 3 is 0, in-service is left unchanged. No in-service bit is set by anything else.
- R7: A write to an in-service byte is ANDed with its current contents. Writes to every other register, including the pending bytes, store the written value.
- R8: An input pin's polarity bit set to 1 makes a rising edge a request, and 0 makes a falling edge a request. Input pin 4 feeds channel 6 and pin 5 feeds channel 7.
- R9: Timer strobe bits 0, 1, 2 and 3 (timers A, B, C, D) feed channels 13, 8, 5 and 4.
- R10: Registers exist only at odd byte offsets. The register index is offset bits 5:1, and indices 24..31 alias 0..7. Even offsets read 0x00 and ignore writes. The register indices are:
  - 0: input port level (read-only)
  - 1: polarity
  - 2: enable high byte
  - 3: enable low byte
  - 4: pending high byte
  - 5: pending low byte
  - 6: in-service high byte
  - 7: in-service low byte
  - 8: mask high byte
  - 9: mask low byte
  - 10: vector

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 6 | Byte offset within the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| gpio_in | input | 8 | General-purpose input pins |
| tmr_req | input | 4 | Timer request strobes A..D |
| irq_o | output | 1 | Interrupt request to the processor |
| iack | input | 1 | One-cycle acknowledge strobe |
| vec_o | output | 8 | Vector for the currently selected channel |

## Verification
The bench uses the default package constants: sixteen channels, a six-bit offset, and a 24-entry register window. The six-bit offset makes index values 24..31 reachable, so the modulo-24 aliasing can be exercised directly through the bus. With all four timer strobes and both routed input pins available, the bench creates simultaneous requests. It also creates in-service blocking chains across the high and low bytes, and exercises both acknowledge modes against a queue of expected vectors.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int NCH      = 16;
    localparam int CH_W     = $clog2(NCH);
    localparam int BYTE_W   = 8;
    localparam int NTMR     = 4;
    localparam int NGP      = 8;
    localparam int NROUTED  = 2;
    localparam int ADDR_W   = 6;
    localparam int IDX_W    = ADDR_W - 1;
    localparam int NREG     = 24;

    // timer strobe bit t feeds channel TMR_CH_MAP[t]
    localparam logic [NTMR*CH_W-1:0] TMR_CH_MAP = {4'd4, 4'd5, 4'd8, 4'd13};

    // routed input pins and their channels, lowest entry first
    localparam logic [NROUTED*3-1:0]    GP_PIN_MAP = {3'd5, 3'd4};
    localparam logic [NROUTED*CH_W-1:0] GP_CH_MAP  = {4'd7, 4'd6};

    localparam int VEC_MODE_BIT = 3;

    typedef enum logic [IDX_W-1:0] {
        RI_PORT    = 5'd0,
        RI_POL     = 5'd1,
        RI_EN_HI   = 5'd2,
        RI_EN_LO   = 5'd3,
        RI_PEND_HI = 5'd4,
        RI_PEND_LO = 5'd5,
        RI_INSV_HI = 5'd6,
        RI_INSV_LO = 5'd7,
        RI_MASK_HI = 5'd8,
        RI_MASK_LO = 5'd9,
        RI_VEC     = 5'd10
    } reg_idx_e;

    typedef struct packed {
        logic             odd;
        logic             wr;
        logic [IDX_W-1:0] idx;
    } bus_dec_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
    } winner_t;

    function automatic logic [IDX_W-1:0] fold_idx(input logic [IDX_W-1:0] raw);
        logic [IDX_W-1:0] lim;
        lim = IDX_W'(NREG);
        return (raw >= lim) ? raw - lim : raw;
    endfunction

    function automatic logic [NCH-1:0] route_req(input logic [NTMR-1:0] tmr,
                                                 input logic [NROUTED-1:0] gp);
        logic [NCH-1:0] r;
        r = '0;
        for (int t = 0; t < NTMR; t++)
            if (tmr[t]) r[TMR_CH_MAP[t*CH_W +: CH_W]] = 1'b1;
        for (int g = 0; g < NROUTED; g++)
            if (gp[g]) r[GP_CH_MAP[g*CH_W +: CH_W]] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/ivc_bus_decode.sv
module ivc_bus_decode
    import ivc_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_dec_t          dec
);
    always_comb begin
        dec.odd = bus_addr[0];
        dec.wr  = bus_sel & bus_wr & bus_addr[0];
        dec.idx = fold_idx(bus_addr[ADDR_W-1:1]);
    end
endmodule

// File: rtl/ivc_edge_detect.sv
module ivc_edge_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] pol,
    output logic [W-1:0] edges
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= pins;
        else     prev_q <= pins;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign edges[i] = pol[i] ? (pins[i] & ~prev_q[i])
                                 : (~pins[i] & prev_q[i]);
    end
endmodule

// File: rtl/ivc_prio_resolve.sv
module ivc_prio_resolve
    import ivc_pkg::*;
(
    input  logic [NCH-1:0] pend,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] insv,
    output winner_t        win
);
    always_comb begin
        logic above;
        above = 1'b0;
        win   = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (!win.valid && !above && pend[c] && mask[c]) begin
                win.valid = 1'b1;
                win.ch    = CH_W'(c);
            end
            above = above | insv[c];
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [NGP-1:0]    gpio_in,
    input  logic [NTMR-1:0]   tmr_req,
    output logic              irq_o,
    input  logic              iack,
    output logic [BYTE_W-1:0] vec_o
);
    localparam int HI = NCH - 1;
    localparam int LO = BYTE_W;

    bus_dec_t       dec;
    winner_t        win;
    logic [NCH-1:0] en_q, pend_q, insv_q, mask_q;
    logic [NCH-1:0] pend_d, insv_d, req;
    logic [NGP-1:0] pol_q, port_q;
    logic [BYTE_W-1:0] vreg_q;
    logic [NROUTED-1:0] gp_pins, gp_pol, gp_edges;
    logic take;

    ivc_bus_decode u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .dec     (dec)
    );

    for (genvar g = 0; g < NROUTED; g++) begin : g_route
        assign gp_pins[g] = gpio_in[GP_PIN_MAP[g*3 +: 3]];
        assign gp_pol[g]  = pol_q[GP_PIN_MAP[g*3 +: 3]];
    end

    ivc_edge_detect #(.W(NROUTED)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pins (gp_pins),
        .pol  (gp_pol),
        .edges(gp_edges)
    );

    ivc_prio_resolve u_prio (
        .pend(pend_q),
        .mask(mask_q),
        .insv(insv_q),
        .win (win)
    );

    assign req   = route_req(tmr_req, gp_edges);
    assign irq_o = win.valid;
    assign vec_o = {vreg_q[BYTE_W-1:4], win.ch};
    assign take  = iack & win.valid;

    // pending: bus write, acknowledge clear, new requests, enable gate
    always_comb begin
        pend_d = pend_q;
        if (dec.wr && dec.idx == RI_PEND_HI) pend_d[HI:LO]   = bus_wdata;
        if (dec.wr && dec.idx == RI_PEND_LO) pend_d[LO-1:0]  = bus_wdata;
        if (take) pend_d[win.ch] = 1'b0;
        pend_d = (pend_d | req) & en_q;
    end

    // in-service: AND-only writes, set on acknowledge in in-service mode
    always_comb begin
        insv_d = insv_q;
        if (dec.wr && dec.idx == RI_INSV_HI) insv_d[HI:LO]  = insv_q[HI:LO] & bus_wdata;
        if (dec.wr && dec.idx == RI_INSV_LO) insv_d[LO-1:0] = insv_q[LO-1:0] & bus_wdata;
        if (take && vreg_q[VEC_MODE_BIT]) insv_d[win.ch] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            insv_q <= '0;
            mask_q <= '0;
            pol_q  <= '0;
            vreg_q <= '0;
            port_q <= '0;
        end else begin
            pend_q <= pend_d;
            insv_q <= insv_d;
            port_q <= gpio_in;
            if (dec.wr) begin
                case (dec.idx)
                    RI_POL:     pol_q          <= bus_wdata;
                    RI_EN_HI:   en_q[HI:LO]    <= bus_wdata;
                    RI_EN_LO:   en_q[LO-1:0]   <= bus_wdata;
                    RI_MASK_HI: mask_q[HI:LO]  <= bus_wdata;
                    RI_MASK_LO: mask_q[LO-1:0] <= bus_wdata;
                    RI_VEC:     vreg_q         <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.odd) begin
            case (dec.idx)
                RI_PORT:    bus_rdata = port_q;
                RI_POL:     bus_rdata = pol_q;
                RI_EN_HI:   bus_rdata = en_q[HI:LO];
                RI_EN_LO:   bus_rdata = en_q[LO-1:0];
                RI_PEND_HI: bus_rdata = pend_q[HI:LO];
                RI_PEND_LO: bus_rdata = pend_q[LO-1:0];
                RI_INSV_HI: bus_rdata = insv_q[HI:LO];
                RI_INSV_LO: bus_rdata = insv_q[LO-1:0];
                RI_MASK_HI: bus_rdata = mask_q[HI:LO];
                RI_MASK_LO: bus_rdata = mask_q[LO-1:0];
                RI_VEC:     bus_rdata = vreg_q;
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              iack,
    input logic [BYTE_W-1:0] vec,
    input logic [NCH-1:0]    pend,
    input logic [NCH-1:0]    mask,
    input logic [NCH-1:0]    insv,
    input logic [NCH-1:0]    en
);
    // R4: a raised request always names a pending, unmasked channel
    p_irq_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend[vec[CH_W-1:0]] && mask[vec[CH_W-1:0]]));

    // R3: no in-service bit above the selected channel
    p_no_higher_insv_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (((insv >> vec[CH_W-1:0]) >> 1) == '0));

    // R2: pending never survives a cycle with its enable bit clear
    p_disabled_cleared_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pend & ~$past(en)) == '0));

    // R6: in-service bits appear only through an acknowledge
    p_insv_only_ack_r6: assert property (@(posedge clk) disable iff (rst)
        !(iack && irq) |=> ((insv & ~$past(insv)) == '0));

    // R6: one acknowledge sets at most one in-service bit
    p_insv_single_r6: assert property (@(posedge clk) disable iff (rst)
        (iack && irq) |=> ($countones(insv & ~$past(insv)) <= 1));
endmodule

bind irq_vec_ctrl ivc_checker u_chk (
    .clk (clk),
    .rst (rst),
    .irq (irq_o),
    .iack(iack),
    .vec (vec_o),
    .pend(pend_q),
    .mask(mask_q),
    .insv(insv_q),
    .en  (en_q)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] gpio_in = '0;
    logic [3:0] tmr_req = '0;
    logic       irq_o;
    logic       iack = 1'b0;
    logic [7:0] vec_o;

    int checks = 0, failures = 0, cycles = 0;
    logic [7:0] exp_q[$];
    bit done = 0;

    always #10 clk = ~clk;

    irq_vec_ctrl u0 (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'(2*idx+1); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic wr_raw(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_raw(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #5 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [7:0] exp);
        logic [7:0] d;
        rd_raw(6'(2*idx+1), d);
        chk(req, d, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        #5 chk(req, {7'b0, irq_o}, {7'b0, exp});
    endtask

    task automatic pulse_tmr(input logic [3:0] m);
        @(negedge clk); tmr_req = m;
        @(negedge clk); tmr_req = '0;
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk); gpio_in[p] = v;
        @(negedge clk);
    endtask

    // driver: push expected vector, pulse acknowledge
    task automatic ack(input logic [7:0] exp_vec);
        @(negedge clk);
        exp_q.push_back(exp_vec);
        iack = 1;
        @(negedge clk);
        iack = 0;
    endtask

    // monitor: compare the vector presented in each acknowledge cycle
    always @(negedge clk) begin
        #5;
        if (iack) begin
            if (exp_q.size() == 0) chk("R5 unexpected ack", vec_o, 8'hxx);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk("R5 vector", vec_o, e);
                chk("R3 irq at ack", {7'b0, irq_o}, 8'h01);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int i = 0; i < 11; i++) rd_chk("R1 reset reg", i, 8'h00);
        irq_chk("R1 reset irq", 1'b0);

        // R2 disabled request ignored
        pulse_tmr(4'b0001);
        rd_chk("R2 ignored pend hi", 4, 8'h00);
        irq_chk("R2 ignored irq", 1'b0);

        wr(2, 8'hFF); wr(3, 8'hFF); wr(8, 8'hFF); wr(9, 8'hFF);
        wr(10, 8'h48);

        // R9 timer A -> ch13, R6 in-service mode
        pulse_tmr(4'b0001);
        rd_chk("R9 timer A pend hi", 4, 8'h20);
        irq_chk("R3 irq raised", 1'b1);
        ack(8'h4D);
        rd_chk("R6 insv hi set", 6, 8'h20);
        rd_chk("R6 pend hi cleared", 4, 8'h00);

        // R3 blocking by higher in-service, R9 timer D -> ch4
        pulse_tmr(4'b1000);
        rd_chk("R9 timer D pend lo", 5, 8'h10);
        irq_chk("R3 blocked by ch13", 1'b0);
        wr(6, 8'hDF);
        rd_chk("R7 insv hi and-clear", 6, 8'h00);
        irq_chk("R3 unblocked", 1'b1);
        ack(8'h44);
        rd_chk("R6 insv lo", 7, 8'h10);
        wr(7, 8'hFF);
        rd_chk("R7 and-write cannot set", 7, 8'h10);
        wr(7, 8'h00);
        rd_chk("R7 insv lo cleared", 7, 8'h00);

        // R3 priority: B (ch8) over C (ch5)
        pulse_tmr(4'b0110);
        ack(8'h48);
        irq_chk("R3 ch8 blocks ch5", 1'b0);
        wr(6, 8'h00);
        ack(8'h45);
        rd_chk("R6 insv lo ch5", 7, 8'h20);
        wr(7, 8'h00);

        // R4 mask
        wr(9, 8'h00);
        pulse_tmr(4'b0100);
        rd_chk("R4 masked still pending", 5, 8'h20);
        irq_chk("R4 masked no irq", 1'b0);
        wr(9, 8'hFF);
        irq_chk("R4 unmasked irq", 1'b1);

        // R6 automatic mode
        wr(10, 8'h40);
        ack(8'h45);
        rd_chk("R6 auto insv stays 0", 7, 8'h00);
        rd_chk("R6 auto pend cleared", 5, 8'h00);

        // R8 edges: pin4 rising, pin5 falling
        wr(1, 8'h10);
        set_pin(4, 1'b1);
        rd_chk("R8 pin4 rise -> ch6", 5, 8'h40);
        ack(8'h46);
        set_pin(4, 1'b0);
        rd_chk("R8 pin4 fall ignored", 5, 8'h00);
        set_pin(5, 1'b1);
        rd_chk("R8 pin5 rise ignored", 5, 8'h00);
        set_pin(5, 1'b0);
        rd_chk("R8 pin5 fall -> ch7", 5, 8'h80);
        ack(8'h47);

        // R7 direct pending write, R2 disable clears pending
        wr(5, 8'h01);
        rd_chk("R7 pend lo direct", 5, 8'h01);
        wr(3, 8'hFE);
        rd_chk("R2 disable clears pend", 5, 8'h00);
        wr(3, 8'hFF);

        // R10 addressing
        begin
            logic [7:0] d;
            rd_raw(6'd6, d);
            chk("R10 even read zero", d, 8'h00);
            wr_raw(6'd20, 8'h00);
            rd_chk("R10 even write ignored", 10, 8'h40);
            rd_raw(6'd51, d);
            chk("R10 alias read idx25", d, 8'h10);
            wr_raw(6'd51, 8'h30);
            rd_chk("R10 alias write idx25", 1, 8'h30);
        end

        repeat (3) @(negedge clk);
        chk("R5 queue drained", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule